// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

The block divides a source clock through a chain of two programmable divider stages. Each stage has its own high-phase length, low-phase length, phase offset, start level and bypass control. The first stage counts cycles of the source clock. The second stage counts rising edges of the first stage's output, so the overall ratio is the product of the two stage ratios. Everything runs in a single fast clock domain. The source clock is presented as a tick input `srcTick`, where one tick is one source period. The divided clock leaves the block as a level `divLvl`, together with a one-cycle `divTick` that marks each of its rising edges.

The phase lengths are stored minus one, so one stage can divide by any ratio from 2 to 32 with any duty cycle. A chip-level synchronisation input holds both stages at their start levels. When it is released, the stages restart in a known phase relationship. A configuration bit can tell the block to ignore synchronisation. In that mode a raised sync input instead parks the output at a selectable static level, and the dividers keep running. All configuration arrives on parallel inputs. A register bank would normally reset the first stage to 2/2 and the second to 1/1.

Top module: `clkDivCascade`

## Requirements
- R1: A dividing stage holds its output high for (high field + 1) input ticks and low for (low field + 1) input ticks. The high and low fields are 4-bit, unsigned and minus-one encoded. Stage 0 (array index 0) counts `srcTick`. Stage 1 counts rising edges of stage 0, so the output widths are (field1 + 1) × (high0 + low0 + 2) source ticks.
- R2: After sync is released, each stage first lets phase-offset ticks pass. It then runs its first phase, at its start level, with the matching field length. The first rising output edge therefore appears at a computed cycle.
- R3: During sync hold, each stage sits at its start level (`startHigh` bit: 1 = high, 0 = low). It begins from that level when released.
- R4: A stage with its `bypass` bit set stops counting. It passes its input level and input tick straight through. With both stages bypassed, `divLvl` equals `srcTick` in the same cycle.
- R5: With `noSync` = 0, a high `syncIn` takes effect through one register stage. The stages are then held with `divLvl` constant. Releasing `syncIn` restarts them: the first source tick is counted two clock edges after `syncIn` is sampled low.
- R6: With `noSync` = 1, `syncIn` does not hold or restart the dividers. While it is high, and one cycle later, `divLvl` is parked at the registered `forceHigh` level and `divTick` is 0.
- R7: A change of a high or low field takes effect at the next phase boundary. The phase in progress keeps its length, so no runt phase appears.
- R8: During reset `divLvl` and `divTick` are 0. Leaving reset acts like a sync release.
- R9: A dividing stage advances only on cycles with its input tick high. With `srcTick` held low, `divLvl` does not change.
- R10: `divTick` is high for one cycle, in the cycle immediately before `divLvl` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all logic is on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 1 | Source clock modelled as a per-cycle tick |
| syncIn | input | 1 | Chip-level synchronisation request, active high |
| noSync | input | 1 | 1 = ignore syncIn for the dividers and park the output instead |
| forceHigh | input | 1 | Parked output level while syncIn is ignored |
| highLen | input | NUM_STAGES×FIELD_W | Per-stage high-phase length minus one |
| lowLen | input | NUM_STAGES×FIELD_W | Per-stage low-phase length minus one |
| phaseOff | input | NUM_STAGES×FIELD_W | Per-stage ticks to wait after sync release |
| startHigh | input | NUM_STAGES | Per-stage start level |
| bypass | input | NUM_STAGES | Per-stage pass-through select |
| divLvl | output | 1 | Divided clock level |
| divTick | output | 1 | One-cycle marker before each rising edge of divLvl |

## Verification
The bench targets the field extremes: zero-length phases, where a stage divides by two, and all-ones fields with a fifteen-tick offset. An off-by-one in the minus-one decoding or in the offset wait shows up there as a width or first-edge time that is wrong by one tick, or by a whole first-stage period. It also covers start-high settings and each bypass on its own. A design that counted stage 1 on stage 0's ticks rather than its rising edges, or that kept counting while bypassed, would give the wrong product. Further tests change a field in mid-phase, pause the source ticks, and pulse sync while sync is ignored. These catch a runt phase, a counter that ignores the tick gate, and a divider that restarts when it should only park its output.

// File: rtl/clkDivPkg.sv
package clkDivPkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic holdStages;  // keep every stage loaded at its start state
    logic parkOut;     // replace the divided output with a static level
    logic parkLvl;     // the static level used while parked
  } divStrobe_t;

  // Stage sequencing: waiting out the phase offset, or counting phases
  typedef enum logic {
    PH_DELAY = 1'b0,
    PH_COUNT = 1'b1
  } stagePhase_t;

  // Suggested register-bank reset values, per stage
  localparam logic [3:0] DFLT_LEN_FIRST  = 4'd2;
  localparam logic [3:0] DFLT_LEN_SECOND = 4'd1;

endpackage

// File: rtl/clkDivCtrl.sv
module clkDivCtrl
  import clkDivPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       noSync,
  input  logic       forceHigh,
  output divStrobe_t strobe
);

  // Reset value holds the stages, so leaving reset behaves like a sync release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe.holdStages <= 1'b1;
      strobe.parkOut    <= 1'b0;
      strobe.parkLvl    <= 1'b0;
    end else begin
      strobe.holdStages <= syncIn & ~noSync;
      strobe.parkOut    <= syncIn & noSync;
      strobe.parkLvl    <= forceHigh;
    end
  end

  // R5: an obeyed sync reaches the stages one edge later
  a_r5_hold_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !noSync) |=> strobe.holdStages);

  // R6: an ignored sync never holds the stages
  a_r6_ignored_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    noSync |=> !strobe.holdStages);

  // R6: an ignored sync parks the output at the requested level
  a_r6_park_level: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && noSync) |=> (strobe.parkOut && (strobe.parkLvl == $past(forceHigh))));

endmodule

// File: rtl/clkDivStage.sv
module clkDivStage
  import clkDivPkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickIn,
  input  logic               lvlIn,
  input  logic               hold,
  input  logic [FIELD_W-1:0] highLen,
  input  logic [FIELD_W-1:0] lowLen,
  input  logic [FIELD_W-1:0] phaseOff,
  input  logic               startHigh,
  input  logic               bypass,
  output logic               lvlOut,
  output logic               tickOut
);

  localparam logic [FIELD_W-1:0] ZERO = '0;
  localparam logic [FIELD_W-1:0] ONE  = FIELD_W'(1);

  logic               lvl;
  logic [FIELD_W-1:0] cnt;
  stagePhase_t        ph;
  logic               lastTick;

  // Final tick of a counted phase: the level flips on this edge
  assign lastTick = tickIn & ~hold & ~bypass & (ph == PH_COUNT) & (cnt == ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl <= 1'b0;
      cnt <= ZERO;
      ph  <= PH_COUNT;
    end else if (hold) begin
      lvl <= startHigh;
      if (phaseOff == ZERO) begin
        ph  <= PH_COUNT;
        cnt <= startHigh ? highLen : lowLen;
      end else begin
        ph  <= PH_DELAY;
        cnt <= phaseOff - ONE;
      end
    end else if (tickIn && !bypass) begin
      if (cnt != ZERO) begin
        cnt <= cnt - ONE;
      end else if (ph == PH_DELAY) begin
        ph  <= PH_COUNT;
        cnt <= lvl ? highLen : lowLen;
      end else begin
        lvl <= ~lvl;
        cnt <= lvl ? lowLen : highLen;  // live field, read only at the boundary
      end
    end
  end

  assign lvlOut  = bypass ? lvlIn  : lvl;
  assign tickOut = bypass ? tickIn : (lastTick & ~lvl);

  // R3/R5: a held stage sits at its start level
  a_r5_hold_level: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> (lvl == $past(startHigh)));

  // R7: no level change while the running phase has ticks left
  a_r7_no_early_flip: assert property (@(posedge clk) disable iff (!rstN)
    ((ph == PH_COUNT) && (cnt != ZERO) && !hold) |=> $stable(lvl));

  // R2: the output stays at its start level while the offset is consumed
  a_r2_delay_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    ((ph == PH_DELAY) && !hold) |=> $stable(lvl));

  // R9: without an input tick the stage state is frozen
  a_r9_idle_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !hold) |=> ($stable(lvl) && $stable(cnt)));

endmodule

// File: rtl/clkDivCascade.sv
module clkDivCascade
  import clkDivPkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter int FIELD_W    = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                srcTick,
  input  logic                                syncIn,
  input  logic                                noSync,
  input  logic                                forceHigh,
  input  logic [NUM_STAGES-1:0][FIELD_W-1:0]  highLen,
  input  logic [NUM_STAGES-1:0][FIELD_W-1:0]  lowLen,
  input  logic [NUM_STAGES-1:0][FIELD_W-1:0]  phaseOff,
  input  logic [NUM_STAGES-1:0]               startHigh,
  input  logic [NUM_STAGES-1:0]               bypass,
  output logic                                divLvl,
  output logic                                divTick
);

  localparam int LAST = NUM_STAGES - 1;

  divStrobe_t              strobe;
  logic [NUM_STAGES:0]     tickChain;
  logic [NUM_STAGES:0]     lvlChain;

  clkDivCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .noSync    (noSync),
    .forceHigh (forceHigh),
    .strobe    (strobe)
  );

  // The source is a tick stream; its level is the tick itself
  assign tickChain[0] = srcTick;
  assign lvlChain[0]  = srcTick;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    clkDivStage #(.FIELD_W(FIELD_W)) u_stage (
      .clk       (clk),
      .rstN      (rstN),
      .tickIn    (tickChain[g]),
      .lvlIn     (lvlChain[g]),
      .hold      (strobe.holdStages),
      .highLen   (highLen[g]),
      .lowLen    (lowLen[g]),
      .phaseOff  (phaseOff[g]),
      .startHigh (startHigh[g]),
      .bypass    (bypass[g]),
      .lvlOut    (lvlChain[g+1]),
      .tickOut   (tickChain[g+1])
    );
  end

  assign divLvl  = strobe.parkOut ? strobe.parkLvl : lvlChain[NUM_STAGES];
  assign divTick = ~strobe.parkOut & tickChain[NUM_STAGES];

  // R10: a marker is followed by a high output unless the whole chain is bypassed
  a_r10_tick_then_rise: assert property (@(posedge clk) disable iff (!rstN)
    (divTick && !syncIn && !(&bypass)) |=> (divLvl || (&bypass)));

  // R6: no marker escapes while the output is parked
  a_r6_parked_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && noSync) |=> !divTick);

  // R1: the last stage only changes level when it may
  a_r1_last_stage_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (!tickChain[LAST] && !strobe.holdStages && !bypass[LAST]) |=> $stable(lvlChain[NUM_STAGES]));

endmodule

// File: tb/clkDivCascade_tb.sv
`timescale 1ns/1ps
module clkDivCascade_tb;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             srcTick = 1'b1;
  logic             syncIn = 1'b0;
  logic             noSync = 1'b0;
  logic             forceHigh = 1'b0;
  logic [1:0][3:0]  highLen;
  logic [1:0][3:0]  lowLen;
  logic [1:0][3:0]  phaseOff;
  logic [1:0]       startHigh;
  logic [1:0]       bypass;
  logic             divLvl;
  logic             divTick;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  clkDivCascade u_dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .syncIn(syncIn),
    .noSync(noSync), .forceHigh(forceHigh), .highLen(highLen),
    .lowLen(lowLen), .phaseOff(phaseOff), .startHigh(startHigh),
    .bypass(bypass), .divLvl(divLvl), .divTick(divTick)
  );

  typedef struct packed {
    logic [3:0]  h1, l1, o1;
    logic        s1, b1;
    logic [3:0]  h2, l2, o2;
    logic        s2, b2;
    logic [11:0] eRise, eHigh, eLow;
  } vec_t;

  // Expected values from R1/R2/R3/R4 (first rise counted in samples after release)
  localparam vec_t VECS [9] = '{
    '{4'd2,  4'd2,  4'd0,  1'b0, 1'b0, 4'd1,  4'd1,  4'd0,  1'b0, 1'b0, 12'd9,    12'd12,  12'd12},
    '{4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 12'd1,    12'd2,   12'd2},
    '{4'd7,  4'd3,  4'd5,  1'b0, 1'b0, 4'd2,  4'd4,  4'd3,  1'b0, 1'b0, 12'd93,   12'd36,  12'd60},
    '{4'd1,  4'd4,  4'd2,  1'b1, 1'b0, 4'd3,  4'd0,  4'd1,  1'b1, 1'b0, 12'd44,   12'd28,  12'd7},
    '{4'd2,  4'd2,  4'd0,  1'b0, 1'b1, 4'd5,  4'd2,  4'd4,  1'b0, 1'b0, 12'd7,    12'd6,   12'd3},
    '{4'd2,  4'd2,  4'd0,  1'b0, 1'b1, 4'd15, 4'd15, 4'd15, 1'b1, 1'b0, 12'd47,   12'd16,  12'd16},
    '{4'd3,  4'd5,  4'd6,  1'b0, 1'b0, 4'd1,  4'd1,  4'd0,  1'b0, 1'b1, 12'd12,   12'd4,   12'd6},
    '{4'd2,  4'd1,  4'd0,  1'b1, 1'b0, 4'd1,  4'd1,  4'd0,  1'b0, 1'b1, 12'd5,    12'd3,   12'd2},
    '{4'd15, 4'd15, 4'd15, 1'b1, 1'b0, 4'd15, 4'd15, 4'd15, 1'b0, 1'b0, 12'd1007, 12'd512, 12'd512}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setDefaults();
    highLen   = {4'd1, 4'd2};
    lowLen    = {4'd1, 4'd2};
    phaseOff  = '0;
    startHigh = '0;
    bypass    = '0;
  endtask

  task automatic applyVec(input vec_t v);
    highLen   = {v.h2, v.h1};
    lowLen    = {v.l2, v.l1};
    phaseOff  = {v.o2, v.o1};
    startHigh = {v.s2, v.s1};
    bypass    = {v.b2, v.b1};
  endtask

  // Holds sync for a few cycles, then releases it at a falling edge
  task automatic restart(output logic pl, output logic pt);
    @(negedge clk);
    syncIn = 1'b1;
    repeat (4) @(negedge clk);
    pl = divLvl;
    pt = divTick;
    syncIn = 1'b0;
  endtask

  task automatic findRise(input logic pl, input logic pt, output int rise, output logic tb);
    logic prevL;
    logic prevT;
    prevL = pl;
    prevT = pt;
    rise = -1;
    tb = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (divLvl && !prevL) begin
        rise = k;
        tb = prevT;
        break;
      end
      prevL = divLvl;
      prevT = divTick;
    end
  endtask

  task automatic runLen(input logic level, output int n);
    n = 1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (divLvl == level) n++;
      else break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic pl, pt, tb;
    int   rise, hw, lw, bad;
    setDefaults();

    // R8: reset state, then reset release behaves like a sync release
    repeat (3) @(negedge clk);
    check(divLvl == 1'b0, "R8 reset level", divLvl, 0);
    check(divTick == 1'b0, "R8 reset tick", divTick, 0);
    pl = divLvl; pt = divTick;
    rstN = 1'b1;
    findRise(pl, pt, rise, tb);
    check(rise == 9, "R8 first rise after reset", rise, 9);

    // Table walk: R1 widths, R2 first rise, R3 start level, R4 bypass, R10 marker
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      applyVec(VECS[i]);
      restart(pl, pt);
      check(pl == (VECS[i].b2 ? VECS[i].s1 : VECS[i].s2), "R3 R5 held start level",
            pl, VECS[i].b2 ? VECS[i].s1 : VECS[i].s2);
      findRise(pl, pt, rise, tb);
      runLen(1'b1, hw);
      runLen(1'b0, lw);
      check(rise == int'(VECS[i].eRise), "R2 first rise", rise, int'(VECS[i].eRise));
      check(hw == int'(VECS[i].eHigh), "R1 R4 high width", hw, int'(VECS[i].eHigh));
      check(lw == int'(VECS[i].eLow), "R1 R4 low width", lw, int'(VECS[i].eLow));
      check(tb == 1'b1, "R10 marker before rise", tb, 1);
    end

    // R9: no source ticks, no movement; counting resumes where it stopped
    @(negedge clk);
    setDefaults();
    restart(pl, pt);
    srcTick = 1'b0;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (divLvl != 1'b0) bad++;
    end
    check(bad == 0, "R9 frozen without ticks", bad, 0);
    pl = divLvl; pt = divTick;
    srcTick = 1'b1;
    findRise(pl, pt, rise, tb);
    check(rise == 8, "R9 resume count", rise, 8);

    // R4: full bypass passes the source tick in the same cycle
    @(negedge clk);
    bypass = 2'b11;
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      srcTick = (k % 3) != 1;
      #1;
      if (divLvl != srcTick || divTick != srcTick) bad++;
    end
    check(bad == 0, "R4 full bypass follows source", bad, 0);
    @(negedge clk);
    srcTick = 1'b1;
    setDefaults();

    // R7: field change in mid-phase waits for the boundary
    highLen = {4'd1, 4'd2};
    bypass  = 2'b01;
    restart(pl, pt);
    findRise(pl, pt, rise, tb);
    check(rise == 2, "R7 setup rise", rise, 2);
    highLen[1] = 4'd5;
    runLen(1'b1, hw);
    check(hw == 2, "R7 running phase keeps old length", hw, 2);
    runLen(1'b0, lw);
    check(lw == 2, "R7 low phase", lw, 2);
    runLen(1'b1, hw);
    check(hw == 6, "R7 new length at boundary", hw, 6);

    // R6: parked output level follows forceHigh, no marker
    @(negedge clk);
    setDefaults();
    noSync = 1'b1;
    forceHigh = 1'b1;
    syncIn = 1'b1;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (divLvl != 1'b1 || divTick != 1'b0) bad++;
    end
    check(bad == 0, "R6 parked high", bad, 0);
    forceHigh = 1'b0;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (divLvl != 1'b0 || divTick != 1'b0) bad++;
    end
    check(bad == 0, "R6 parked low", bad, 0);
    syncIn = 1'b0;

    // R6: ignored sync does not restart the dividers
    noSync = 1'b0;
    restart(pl, pt);
    findRise(pl, pt, rise, tb);
    noSync = 1'b1;
    forceHigh = 1'b1;
    pl = divLvl;
    rise = -1;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (divLvl && !pl) begin
        rise = k;
        break;
      end
      pl = divLvl;
      if (k == 3) syncIn = 1'b1;
      if (k == 5) syncIn = 1'b0;
    end
    check(rise == 24, "R6 period unaffected by ignored sync", rise, 24);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule